// File: doc/BRIEF.md
# USB Device Address Register and Token Filter

This block keeps the bus address of a USB device and decides, for every decoded token, whether the token is meant for this device. Software uses a one-cycle register write port to reach two things: a 7-bit address field and a separate enable bit. The address in force for filtering is the stored address while the enable bit is set, and zero at all other times.

The usual software flow has three steps. First, the address from the host's address-assignment request is written with the enable bit at zero. Next, the zero-length status stage is completed. Finally, a second write sets the enable bit and repeats the same address. A write that sets the enable bit and also carries a different address is rejected and recorded in a sticky error flag.

Three causes clear the address, the enable bit and the error flag together: hardware reset, the controller-enable input going low, and a USB bus-reset pulse. Whenever the address is cleared, the filter falls back to address zero.

Top module: `usbaddr_filter`

## Requirements
- R1: While the asynchronous hardware reset `rst_n` is low and after it is released, `eff_addr` is 0, `addr_enabled` is 0 and `cfg_err` is 0.
- R2: A write (`wr_en`=1) whose enable bit (`wr_data[7]`) is 0 stores `wr_data[6:0]` as the pending address. It also clears `addr_enabled`, and from the next cycle `eff_addr` reads 0.
- R3: A write whose bit 7 is 1 and whose `wr_data[6:0]` equals the stored address sets `addr_enabled`. From the next cycle `eff_addr` equals the stored address.
- R4: A write whose bit 7 is 1 and whose `wr_data[6:0]` differs from the stored address is an error. `addr_enabled` is cleared, the stored address is kept and `cfg_err` is set. `cfg_err` then stays at 1 until one of the clear causes.
- R5: While `ctrl_en` is 0, the stored address, `addr_enabled` and `cfg_err` are cleared on the next edge, and any write in that cycle is discarded.
- R6: A `bus_rst` pulse clears the stored address, `addr_enabled` and `cfg_err` on the next edge. It takes priority over a write in the same cycle.
- R7: `tok_accept` is combinational: it is 1 exactly when `tok_valid` is 1 and all 7 bits of `tok_addr` equal `eff_addr`.
- R8: When no address is enabled, only tokens addressed to 0 are accepted.
- R9: Cycles with `wr_en` at 0 change neither the stored address nor `addr_enabled` nor `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ctrl_en | input | 1 | Controller enable; low clears the address state |
| bus_rst | input | 1 | USB bus-reset detected pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bits 6:0 address, bit 7 enable |
| tok_valid | input | 1 | Decoded token strobe |
| tok_addr | input | 7 | Address field of the decoded token |
| eff_addr | output | 7 | Address in force for filtering |
| addr_enabled | output | 1 | Stored address is enabled |
| cfg_err | output | 1 | Sticky flag for a combined address-and-enable write |
| tok_accept | output | 1 | Token is addressed to this device |

## Verification
Register updates from a write, a disable or a bus reset happen on the clock edge where the request is presented. They appear on `eff_addr`, `addr_enabled` and `cfg_err` one cycle later. `tok_accept` responds in the same cycle as its inputs. The bench therefore drives each cycle's inputs at the falling edge and checks `tok_accept` shortly after that, still before the rising edge, against the model state of the previous edge. It then moves its model across the rising edge and checks the registered outputs just after that edge.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_STORE = 2'd1,
      WR_ARM   = 2'd2,
      WR_BAD   = 2'd3
   } wr_kind_e;
endpackage

// File: rtl/uaf_regs.sv
module uaf_regs
   import uaf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_enbit,
   output logic [ADDR_W-1:0] stored,
   output logic              enabled,
   output logic              err
);
   wr_kind_e          kind;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic              en_q, en_d, err_q, err_d;

   always_comb begin
      if (!wr_en)                kind = WR_NONE;
      else if (!wr_enbit)        kind = WR_STORE;
      else if (wr_addr == addr_q) kind = WR_ARM;
      else                       kind = WR_BAD;
   end

   always_comb begin
      addr_d = addr_q;
      en_d   = en_q;
      err_d  = err_q;
      if (clr) begin
         addr_d = '0;
         en_d   = 1'b0;
         err_d  = 1'b0;
      end else begin
         unique case (kind)
            WR_STORE: begin
               addr_d = wr_addr;
               en_d   = 1'b0;
            end
            WR_ARM:   en_d = 1'b1;
            WR_BAD: begin
               en_d  = 1'b0;
               err_d = 1'b1;
            end
            default: ;
         endcase
      end
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q <= '0;
            en_q   <= 1'b0;
            err_q  <= 1'b0;
         end else begin
            addr_q <= addr_d;
            en_q   <= en_d;
            err_q  <= err_d;
         end
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q <= '0;
            en_q   <= 1'b0;
            err_q  <= 1'b0;
         end else begin
            addr_q <= addr_d;
            en_q   <= en_d;
            err_q  <= err_d;
         end
      end
   end

   assign stored  = addr_q;
   assign enabled = en_q;
   assign err     = err_q;
endmodule

// File: rtl/uaf_match.sv
module uaf_match #(
   parameter int unsigned ADDR_W = 7
) (
   input  logic              tok_valid,
   input  logic [ADDR_W-1:0] tok_addr,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              hit
);
   logic [ADDR_W-1:0] bit_eq;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign bit_eq[i] = ~(tok_addr[i] ^ own_addr[i]);
   end

   assign hit = tok_valid & (&bit_eq);
endmodule

// File: rtl/usbaddr_filter.sv
module usbaddr_filter #(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_LSB  = 0,
   parameter int unsigned EN_BIT    = 7,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_en,
   input  logic              bus_rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tok_valid,
   input  logic [ADDR_W-1:0] tok_addr,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              addr_enabled,
   output logic              cfg_err,
   output logic              tok_accept
);
   localparam int unsigned FIELD_HI = ADDR_LSB + ADDR_W - 1;

   if (FIELD_HI >= DATA_W) begin : g_bad_field
      $error("address field does not fit in the write word");
   end
   if (EN_BIT >= DATA_W) begin : g_bad_en
      $error("enable bit lies outside the write word");
   end
   if (EN_BIT >= ADDR_LSB && EN_BIT <= FIELD_HI) begin : g_overlap
      $error("enable bit overlaps the address field");
   end

   logic [ADDR_W-1:0] stored;
   logic              enabled;
   logic              clr;

   assign clr = !ctrl_en || bus_rst;

   uaf_regs #(.ADDR_W(ADDR_W), .ASYNC_RST(ASYNC_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_en   (wr_en),
      .wr_addr (wr_data[FIELD_HI:ADDR_LSB]),
      .wr_enbit(wr_data[EN_BIT]),
      .stored  (stored),
      .enabled (enabled),
      .err     (cfg_err)
   );

   assign eff_addr     = enabled ? stored : '0;
   assign addr_enabled = enabled;

   uaf_match #(.ADDR_W(ADDR_W)) u_match (
      .tok_valid(tok_valid),
      .tok_addr (tok_addr),
      .own_addr (eff_addr),
      .hit      (tok_accept)
   );
endmodule

// File: rtl/uaf_chk.sv
module uaf_chk #(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned EN_BIT   = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_en,
   input logic              bus_rst,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              tok_valid,
   input logic [ADDR_W-1:0] tok_addr,
   input logic [ADDR_W-1:0] eff_addr,
   input logic              addr_enabled,
   input logic              cfg_err,
   input logic              tok_accept
);
   AST_STORE_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[EN_BIT] && ctrl_en && !bus_rst) |=> (!addr_enabled && eff_addr == '0)); // R2
   AST_ERR_LEAVES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> !addr_enabled); // R4
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && ctrl_en && !bus_rst) |=> cfg_err); // R4
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> (eff_addr == '0 && !addr_enabled && !cfg_err)); // R5
   AST_BUSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (eff_addr == '0 && !addr_enabled && !cfg_err)); // R6
   AST_ACCEPT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      tok_accept |-> (tok_valid && tok_addr == eff_addr)); // R7
   AST_ACCEPT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_enabled && tok_accept) |-> tok_addr == '0); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && ctrl_en && !bus_rst) |=> ($stable(eff_addr) && $stable(addr_enabled) && $stable(cfg_err))); // R9
endmodule

bind usbaddr_filter uaf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .bus_rst(bus_rst),
   .wr_en(wr_en), .wr_data(wr_data), .tok_valid(tok_valid), .tok_addr(tok_addr),
   .eff_addr(eff_addr), .addr_enabled(addr_enabled), .cfg_err(cfg_err),
   .tok_accept(tok_accept)
);

// File: tb/tb_usbaddr_filter.sv
`timescale 1ns/1ps
module tb_usbaddr_filter;
   logic       clk = 1'b0;
   logic       rst_n, ctrl_en, bus_rst, wr_en, tok_valid;
   logic [7:0] wr_data;
   logic [6:0] tok_addr, eff_addr;
   logic       addr_enabled, cfg_err, tok_accept;

   int checks = 0;
   int errors = 0;

   logic [6:0] m_addr;
   logic       m_en, m_err;

   always #5 clk = ~clk;

   usbaddr_filter dut (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .bus_rst(bus_rst),
      .wr_en(wr_en), .wr_data(wr_data), .tok_valid(tok_valid), .tok_addr(tok_addr),
      .eff_addr(eff_addr), .addr_enabled(addr_enabled), .cfg_err(cfg_err),
      .tok_accept(tok_accept)
   );

   function automatic logic [6:0] exp_eff();
      return m_en ? m_addr : 7'd0;
   endfunction

   function automatic logic exp_acc(logic v, logic [6:0] a);
      return v && (a == exp_eff());
   endfunction

   task automatic model_edge(logic we, logic [7:0] d, logic ce, logic br);
      if (!ce || br) begin
         m_addr = 0; m_en = 0; m_err = 0;
      end else if (we) begin
         if (!d[7]) begin
            m_addr = d[6:0]; m_en = 0;
         end else if (d[6:0] == m_addr) begin
            m_en = 1;
         end else begin
            m_en = 0; m_err = 1;
         end
      end
   endtask

   task automatic chk(string rq, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic chk_regs(string rq);
      chk(rq, {eff_addr, addr_enabled, cfg_err}, {exp_eff(), m_en, m_err});
   endtask

   task automatic cyc(logic we, logic [7:0] d, logic ce, logic br,
                      logic tv, logic [6:0] ta, string rq);
      @(negedge clk);
      wr_en = we; wr_data = d; ctrl_en = ce; bus_rst = br;
      tok_valid = tv; tok_addr = ta;
      #1;
      chk(m_en ? "R7" : "R8", {8'd0, tok_accept}, {8'd0, exp_acc(tv, ta)});
      @(posedge clk);
      model_edge(we, d, ce, br);
      #1;
      chk_regs(rq);
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 0; wr_en = 0; wr_data = 0; ctrl_en = 1; bus_rst = 0;
      tok_valid = 0; tok_addr = 0;
      m_addr = 0; m_en = 0; m_err = 0;
      #1;
      chk_regs("R1");
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk_regs("R1");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      hw_reset();
      // R2: store without enable keeps filter at 0
      cyc(1, 8'h2A, 1, 0, 1, 7'h00, "R2");
      cyc(0, 8'h00, 1, 0, 1, 7'h2A, "R9");
      // R3: arm with matching address
      cyc(1, 8'hAA, 1, 0, 1, 7'h00, "R3");
      cyc(0, 8'h00, 1, 0, 1, 7'h2A, "R7");
      cyc(0, 8'h00, 1, 0, 1, 7'h2B, "R7");
      cyc(0, 8'h00, 1, 0, 1, 7'h6A, "R7");
      cyc(0, 8'h00, 1, 0, 0, 7'h2A, "R7");
      cyc(0, 8'h00, 1, 0, 1, 7'h00, "R8");
      // R9: data on bus without strobe
      cyc(0, 8'h11, 1, 0, 0, 7'h00, "R9");
      // R6: bus reset clears
      cyc(0, 8'h00, 1, 1, 0, 7'h00, "R6");
      // R4: mismatched arm
      cyc(1, 8'h15, 1, 0, 0, 7'h00, "R2");
      cyc(1, 8'h96, 1, 0, 1, 7'h16, "R4");
      cyc(0, 8'h00, 1, 0, 1, 7'h00, "R4");
      cyc(1, 8'h95, 1, 0, 1, 7'h00, "R4");
      cyc(0, 8'h00, 1, 0, 1, 7'h15, "R4");
      // R6: bus reset wins over same-cycle arm
      cyc(1, 8'h95, 1, 1, 0, 7'h00, "R6");
      cyc(1, 8'h95, 1, 0, 0, 7'h00, "R6");
      // R5: disable drops a write and clears
      cyc(1, 8'h33, 1, 0, 0, 7'h00, "R2");
      cyc(1, 8'h44, 0, 0, 0, 7'h00, "R5");
      cyc(1, 8'hB3, 1, 0, 0, 7'h00, "R5");
      cyc(1, 8'h80, 1, 0, 0, 7'h00, "R5");
      cyc(0, 8'h00, 0, 0, 1, 7'h00, "R5");
      // R3: top address value
      cyc(1, 8'h7F, 1, 0, 0, 7'h00, "R2");
      cyc(1, 8'hFF, 1, 0, 1, 7'h7F, "R3");
      cyc(0, 8'h00, 1, 0, 1, 7'h7F, "R7");
      cyc(0, 8'h00, 1, 0, 1, 7'h3F, "R7");
      // R1: hardware reset mid-run
      hw_reset();
      cyc(0, 8'h00, 1, 0, 1, 7'h00, "R8");
      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic we, ce, br, tv, eb;
         logic [6:0] wa, ta;
         string rq;
         we = ($urandom % 10) < 4;
         ce = ($urandom % 20) != 0;
         br = ($urandom % 25) == 0;
         tv = ($urandom % 4) != 0;
         eb = $urandom % 2;
         wa = ($urandom % 3 == 0) ? m_addr : 7'($urandom);
         case ($urandom % 4)
            0: ta = exp_eff();
            1: ta = 7'd0;
            2: ta = exp_eff() ^ 7'(1 << ($urandom % 7));
            default: ta = 7'($urandom);
         endcase
         if (br) rq = "R6";
         else if (!ce) rq = "R5";
         else if (!we) rq = "R9";
         else if (!eb) rq = "R2";
         else if (wa == m_addr) rq = "R3";
         else rq = "R4";
         cyc(we, {eb, wa}, ce, br, tv, ta, rq);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule